// File: doc/BRIEF.md
# Receive Polarity Detect-and-Lock Controller

A twisted-pair receiver can be wired with its two conductors swapped. The end-of-transmission delimiter at the close of each packet shows whether the line is reversed. This controller takes a per-packet strobe, raised only when that delimiter was valid, together with the polarity the delimiter implied. From these it decides whether the receive data path must be inverted.

The controller works in two stages. The first qualified packet after reset or a link failure sets the inversion directly. Later qualified packets either confirm that setting or replace it. Once a run of agreeing packets reaches the confirmation target (two by default), the decision is frozen. Only a link failure or reset releases the freeze. A status bit mirrors the decision so that software or an indicator can show that reversed polarity is being corrected.

Top module: `rx_pol_lock`

## Requirements
- R1: While reset is asserted, and right after it, `invert_o`, `lock_o` and `pol_o` are all 0.
- R2: The first `etd_valid_i` pulse after reset or after a link failure copies `etd_rev_i` (1 = reversed) into `invert_o` on the next clock edge, whatever its previous value. It never sets `lock_o`, even when the new value equals the old one.
- R3: When the count of consecutive qualified packets that agree with `invert_o` reaches AGREE_TARGET (default 2, the adopting packet included), `lock_o` rises on the clock edge that samples the confirming pulse.
- R4: A qualified packet whose polarity differs from `invert_o` loads the new polarity into `invert_o`, leaves `lock_o` at 0 and restarts the agreement count at one.
- R5: In cycles without an `etd_valid_i` pulse, `etd_rev_i` has no effect on `invert_o` or on the agreement count.
- R6: While `lock_o` is 1, qualified packets leave `invert_o` and `lock_o` unchanged.
- R7: `link_fail_i` clears `lock_o` and the agreement count on the next edge. It keeps `invert_o`, and it takes priority over an `etd_valid_i` pulse in the same cycle, which is then discarded.
- R8: `pol_o` is 1 exactly when `invert_o` is 1, meaning reversed polarity is being corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| etd_valid_i | input | 1 | One-cycle pulse: a packet ended with a valid delimiter |
| etd_rev_i | input | 1 | Polarity implied by that delimiter, 1 = reversed |
| link_fail_i | input | 1 | Link failure indication |
| invert_o | output | 1 | Invert-enable for the receive data path |
| lock_o | output | 1 | Polarity decision is frozen |
| pol_o | output | 1 | Reversed-polarity status for software or an indicator |

## Verification
The sequence first adopts reversed polarity, then flips to normal and confirms it. This separates replacing the setting from taking the lock. Polarity changes sent without a strobe, and strobes sent after the lock, show that neither moves the decision. Link failure is applied both alone and together with a strobe. After it, a first packet that matches the retained setting must not lock, which shows that the count really restarted. A mid-run reset closes the sequence.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;

   localparam int unsigned AGREE_DEFAULT = 2;

   function automatic int unsigned agree_cnt_width(input int unsigned target);
      return $clog2(target + 1);
   endfunction

endpackage

// File: rtl/rx_pol_track.sv
module rx_pol_track (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic rev_i,
   output logic inv_o,
   output logic agree_o
);

   logic inv_q;

   // Each accepted packet loads its polarity; an agreeing one rewrites the same value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         inv_q <= 1'b0;
      else if (take_i)
         inv_q <= rev_i;
   end

   assign inv_o   = inv_q;
   assign agree_o = (rev_i == inv_q);

endmodule

// File: rtl/rx_pol_confirm.sv
module rx_pol_confirm #(
   parameter int unsigned AGREE_TARGET = rx_pol_pkg::AGREE_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic take_i,
   input  logic agree_i,
   output logic lock_o
);

   generate
      if (AGREE_TARGET == 2) begin : g_flag
         logic seen_q;
         logic lock_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= 1'b0;
               lock_q <= 1'b0;
            end else if (clear_i) begin
               seen_q <= 1'b0;
               lock_q <= 1'b0;
            end else if (take_i) begin
               seen_q <= 1'b1;
               if (seen_q && agree_i)
                  lock_q <= 1'b1;
            end
         end

         assign lock_o = lock_q;
      end else begin : g_count
         localparam int unsigned CNT_W = rx_pol_pkg::agree_cnt_width(AGREE_TARGET);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(AGREE_TARGET - 1);
         logic [CNT_W-1:0] cnt_q;
         logic             lock_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               lock_q <= 1'b0;
            end else if (clear_i) begin
               cnt_q  <= '0;
               lock_q <= 1'b0;
            end else if (take_i) begin
               if (cnt_q == '0) begin
                  cnt_q <= CNT_W'(1);
               end else if (agree_i) begin
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (cnt_q == LAST)
                     lock_q <= 1'b1;
               end else begin
                  cnt_q <= CNT_W'(1);
               end
            end
         end

         assign lock_o = lock_q;
      end
   endgenerate

endmodule

// File: rtl/rx_pol_lock.sv
module rx_pol_lock #(
   parameter int unsigned AGREE_TARGET = rx_pol_pkg::AGREE_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic etd_valid_i,
   input  logic etd_rev_i,
   input  logic link_fail_i,
   output logic invert_o,
   output logic lock_o,
   output logic pol_o
);

   generate
      if (AGREE_TARGET < 2) begin : g_bad_target
         $error("rx_pol_lock: AGREE_TARGET must be at least 2");
      end
   endgenerate

   logic take;
   logic agree;
   logic inv;
   logic locked;

   // Link failure wins over a strobe; a frozen decision ignores strobes.
   assign take = etd_valid_i && !link_fail_i && !locked;

   rx_pol_track i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .rev_i   (etd_rev_i),
      .inv_o   (inv),
      .agree_o (agree)
   );

   rx_pol_confirm #(.AGREE_TARGET(AGREE_TARGET)) i_confirm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (link_fail_i),
      .take_i  (take),
      .agree_i (agree),
      .lock_o  (locked)
   );

   assign invert_o = inv;
   assign lock_o   = locked;
   assign pol_o    = inv;

endmodule

// File: rtl/rx_pol_lock_chk.sv
module rx_pol_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic etd_valid_i,
   input logic etd_rev_i,
   input logic link_fail_i,
   input logic invert_o,
   input logic lock_o,
   input logic pol_o
);

   AST_ADOPT_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (etd_valid_i && !link_fail_i && !lock_o) |=> (invert_o == $past(etd_rev_i))); // R2

   AST_LOCK_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> ($past(etd_valid_i) && ($past(etd_rev_i) == invert_o))); // R3

   AST_IDLE_KEEPS_POL: assert property (@(posedge clk) disable iff (!rst_n)
      !etd_valid_i |=> $stable(invert_o)); // R5

   AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && !link_fail_i) |=> (lock_o && $stable(invert_o))); // R6

   AST_FAIL_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      link_fail_i |=> (!lock_o && $stable(invert_o))); // R7

   AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(invert_o) |-> $changed(pol_o)); // R8

endmodule

bind rx_pol_lock rx_pol_lock_chk i_chk (.*);

// File: tb/test_rx_pol_lock.sv
module test_rx_pol_lock;

   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic etd_valid_i = 1'b0;
   logic etd_rev_i = 1'b0;
   logic link_fail_i = 1'b0;
   logic invert_o, lock_o, pol_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  inv;
      logic  lock;
      string tag;
   } exp_t;

   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_pol_lock i_rx_pol_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .etd_valid_i (etd_valid_i),
      .etd_rev_i   (etd_rev_i),
      .link_fail_i (link_fail_i),
      .invert_o    (invert_o),
      .lock_o      (lock_o),
      .pol_o       (pol_o)
   );

   task automatic compare(input string what, input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // Monitor: outputs are registered, so sampling at the falling edge is race-free.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         compare("invert_o", e.tag, invert_o, e.inv);
         compare("lock_o",   e.tag, lock_o,   e.lock);
         compare("pol_o",    "R8",  pol_o,    e.inv);
      end
   end

   // Driver: apply inputs for one cycle, then queue the result due after that edge.
   task automatic step(input logic v, input logic r, input logic f,
                       input logic ei, input logic el, input string tag);
      exp_t e;
      @(negedge clk);
      etd_valid_i = v;
      etd_rev_i   = r;
      link_fail_i = f;
      @(posedge clk);
      e.inv = ei; e.lock = el; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic apply_reset();
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      etd_valid_i = 1'b0;
      link_fail_i = 1'b0;
      @(posedge clk);
      e.inv = 1'b0; e.lock = 1'b0; e.tag = "R1";
      exp_q.push_back(e);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 0, 0, 0, 0, "R1");  // reset state
      step(1, 1, 0, 1, 0, "R2");  // first packet adopts reversed
      step(0, 0, 0, 1, 0, "R5");  // polarity without strobe ignored
      step(1, 0, 0, 0, 0, "R4");  // disagreement replaces, no lock
      step(1, 0, 0, 0, 1, "R3");  // agreement locks
      step(1, 1, 0, 0, 1, "R6");  // locked: strobe ignored
      step(0, 1, 0, 0, 1, "R6");
      step(1, 1, 1, 0, 0, "R7");  // link fail beats strobe, unlocks
      step(1, 0, 0, 0, 0, "R2");  // first after fail, same value, no lock
      step(1, 1, 0, 1, 0, "R4");  // disagreement restarts count
      step(0, 0, 0, 1, 0, "R5");
      step(1, 1, 0, 1, 1, "R3");  // lock on reversed polarity
      step(0, 0, 1, 1, 0, "R7");  // link fail alone keeps inversion
      step(1, 1, 0, 1, 0, "R2");  // adopt after fail
      step(1, 1, 0, 1, 1, "R3");
      apply_reset();              // mid-run reset
      step(0, 1, 0, 0, 0, "R1");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule